// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management register set of an Ethernet PHY, reached through a pair of bus-visible registers: a command word and a data word. Software writes the data word first when it wants to store something. It then writes a command that names a PHY address, a register index and a direction. The access completes on the same clock edge as the command write. A read loads the selected PHY register into the data word. A write moves the low 16 bits of the data word into the selected PHY register.

The model holds a writable control register and a writable advertisement register. It also returns status, identifier and link-partner values, where only the status link bit varies: it follows the `link_up` input after one sampling register. A command whose PHY address does not match the `PHY_ADDR` parameter has no effect on any register. The serial management waveform and real autonegotiation are not modelled.

Top module: `phy_mgmt_model`

## Requirements
- R1: After synchronous reset, the command word and the data word read 0, the control register (index 0) holds 0x3100 and the advertisement register (index 4) holds 0.
- R2: A bus write to word address 0 stores the value as the command word with bit 0 (busy) cleared. Command fields: PHY address in bits 15:12, register index in bits 7:4, bit 1 = 1 for a write and 0 for a read.
- R3: A command whose bits 15:12 differ from `PHY_ADDR` changes neither the data word nor any PHY register.
- R4: A command that writes index 0 with data bit 15 clear stores data bits 15:0 with bits 15 and 9 forced to 0.
- R5: A command that writes index 0 with data bit 15 set restores control to 0x3100 and advertisement to 0, and leaves the status link bit unchanged.
- R6: A read of index 1 returns 0xFE28 with bit 2 equal to `link_up` as sampled on the previous clock edge.
- R7: Indices 2 and 3 read 0x0044 and 0x1400, and writes to them have no effect.
- R8: Index 5 reads 0x0DE0, and writes to it have no effect.
- R9: Index 4 stores data bits 15:0 on a write command and returns them on a read.
- R10: Reads of indices 6 to 15 return 0, and writes to them have no effect.
- R11: A bus write to word address 1 stores the data word. `bus_rdata` shows the word at `bus_addr` (0 = command, 1 = data, others 0) one clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Word address: 0 command, 1 data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the word at bus_addr |
| link_up | input | 1 | Link state fed to status bit 2 |

## Verification
A corrupted control or advertisement register stays hidden until a read command copies it into the data word. It shows at `bus_rdata` two edges after that command. A wrong address match or a wrong direction decode shows up as a changed or unchanged data word on the very next read. A late or early link sample shows only when a status read falls in the cycle of a link change, so that case is driven on purpose.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W      = 16;
  // command word field positions
  localparam int CMD_BUSY   = 0;
  localparam int CMD_WRITE  = 1;
  localparam int CMD_IDX_LO = 4;
  localparam int CMD_PHY_LO = 12;
  // register indices
  localparam logic [3:0] IDX_CTRL = 4'd0;
  localparam logic [3:0] IDX_STAT = 4'd1;
  localparam logic [3:0] IDX_ID_H = 4'd2;
  localparam logic [3:0] IDX_ID_L = 4'd3;
  localparam logic [3:0] IDX_ADV  = 4'd4;
  localparam logic [3:0] IDX_LP   = 4'd5;
  // fixed values
  localparam logic [REG_W-1:0] CTRL_DEFAULT = 16'h3100;
  localparam logic [REG_W-1:0] CTRL_KEEP    = 16'h7DFF;  // bits 15 and 9 dropped
  localparam int               CTRL_RST_BIT = 15;
  localparam logic [REG_W-1:0] STAT_FIXED   = 16'hFE28;
  localparam int               STAT_LINK    = 2;
  localparam logic [REG_W-1:0] ID_HIGH      = 16'h0044;
  localparam logic [REG_W-1:0] ID_LOW       = 16'h1400;
  localparam logic [REG_W-1:0] LP_ABILITY   = 16'h0DE0;
endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PHY_AW   = 4,
  parameter int IDX_W    = 4,
  parameter int PHY_ADDR = 1
) (
  input  logic [DATA_W-1:0] cmd_word,
  output logic              addr_hit,
  output logic              is_write,
  output logic [IDX_W-1:0]  reg_idx
);
  localparam logic [PHY_AW-1:0] OWN_ADDR = PHY_AW'(PHY_ADDR);

  always_comb begin
    addr_hit = (cmd_word[CMD_PHY_LO +: PHY_AW] == OWN_ADDR);
    is_write = cmd_word[CMD_WRITE];
    reg_idx  = cmd_word[CMD_IDX_LO +: IDX_W];
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_write,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] wr_val,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] adv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= '0;
    end else if (do_write) begin
      if (reg_idx == IDX_W'(IDX_CTRL)) begin
        if (wr_val[CTRL_RST_BIT]) begin
          ctrl_q <= CTRL_DEFAULT;
          adv_q  <= '0;
        end else begin
          ctrl_q <= wr_val & CTRL_KEEP;
        end
      end else if (reg_idx == IDX_W'(IDX_ADV)) begin
        adv_q <= wr_val;
      end
    end
  end
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
  import phy_mgmt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] ctrl_q,
  input  logic [REG_W-1:0] adv_q,
  input  logic             link_q,
  output logic [REG_W-1:0] rd_val
);
  always_comb begin
    case (reg_idx)
      IDX_W'(IDX_CTRL): rd_val = ctrl_q;
      IDX_W'(IDX_STAT): rd_val = STAT_FIXED | (REG_W'(link_q) << STAT_LINK);
      IDX_W'(IDX_ID_H): rd_val = ID_HIGH;
      IDX_W'(IDX_ID_L): rd_val = ID_LOW;
      IDX_W'(IDX_ADV):  rd_val = adv_q;
      IDX_W'(IDX_LP):   rd_val = LP_ABILITY;
      default:          rd_val = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int PHY_AW   = 4,
  parameter int IDX_W    = 4,
  parameter int PHY_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              link_up
);
  localparam logic [ADDR_W-1:0] WA_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] WA_DATA = ADDR_W'(1);

  logic [DATA_W-1:0] cmd_q, data_q;
  logic              link_q;
  logic              addr_hit, is_write;
  logic [IDX_W-1:0]  reg_idx;
  logic [REG_W-1:0]  ctrl_q, adv_q, rd_val;
  logic              cmd_wr, exec_rd, exec_wr;

  assign cmd_wr  = bus_wr && (bus_addr == WA_CMD);
  assign exec_rd = cmd_wr && addr_hit && !is_write;
  assign exec_wr = cmd_wr && addr_hit && is_write;

  phy_cmd_decode #(
    .DATA_W(DATA_W), .PHY_AW(PHY_AW), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)
  ) u_dec (
    .cmd_word(bus_wdata), .addr_hit(addr_hit), .is_write(is_write), .reg_idx(reg_idx)
  );

  phy_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .do_write(exec_wr), .reg_idx(reg_idx),
    .wr_val(data_q[REG_W-1:0]), .ctrl_q(ctrl_q), .adv_q(adv_q)
  );

  phy_read_mux #(.IDX_W(IDX_W)) u_mux (
    .reg_idx(reg_idx), .ctrl_q(ctrl_q), .adv_q(adv_q), .link_q(link_q), .rd_val(rd_val)
  );

  // link sampler runs through reset so status always tracks the wire
  always_ff @(posedge clk) link_q <= link_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr) begin
        cmd_q <= bus_wdata & ~(DATA_W'(1) << CMD_BUSY);
      end
      if (bus_wr && bus_addr == WA_DATA) begin
        data_q <= bus_wdata;
      end else if (exec_rd) begin
        data_q <= DATA_W'(rd_val);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        WA_CMD:  bus_rdata <= cmd_q;
        WA_DATA: bus_rdata <= data_q;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int PHY_ADDR = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              link_up,
  input logic              link_q,
  input logic [DATA_W-1:0] cmd_q,
  input logic [DATA_W-1:0] data_q,
  input logic [15:0]       ctrl_q,
  input logic [15:0]       adv_q
);
  logic is_cmd;
  assign is_cmd = bus_wr && (bus_addr == ADDR_W'(0));

  AST_BUSY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> (cmd_q[0] == 1'b0)); // R2

  AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && bus_wdata[15:12] != 4'(PHY_ADDR))
      |=> ($stable(data_q) && $stable(ctrl_q) && $stable(adv_q))); // R3

  AST_CTRL_SELFCLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[15] == 1'b0) && (ctrl_q[9] == 1'b0)); // R4

  AST_LINK_SAMPLED: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |=> link_q); // R6

  AST_ID_HIGH_READ: assert property (@(posedge clk) disable iff (rst)
    (is_cmd && bus_wdata[15:12] == 4'(PHY_ADDR) && bus_wdata[7:4] == 4'd2 && !bus_wdata[1])
      |=> (data_q == DATA_W'(16'h0044))); // R7
endmodule

bind phy_mgmt_model phy_mgmt_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PHY_ADDR(PHY_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .link_up(link_up), .link_q(link_q), .cmd_q(cmd_q), .data_q(data_q),
  .ctrl_q(ctrl_q), .adv_q(adv_q)
);

// File: tb/tb_phy_mgmt_model.sv
module tb_phy_mgmt_model;
  localparam int CLK_PERIOD = 10;
  localparam int PHY = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        link_up = 1'b1;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [31:0] m_cmd, m_data;
  logic [15:0] m_ctrl, m_adv;
  logic        m_link;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_model #(.PHY_ADDR(PHY)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_up(link_up)
  );

  function automatic logic [15:0] model_read(input logic [3:0] idx);
    case (idx)
      4'd0: return m_ctrl;
      4'd1: return 16'hFE28 | {13'd0, m_link, 2'd0};
      4'd2: return 16'h0044;
      4'd3: return 16'h1400;
      4'd4: return m_adv;
      4'd5: return 16'h0DE0;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [3:0] pa, input logic [3:0] idx,
                                         input logic wr);
    return {16'd0, pa, 4'd0, idx, 2'b00, wr, 1'b1};
  endfunction

  task automatic model_cmd(input logic [31:0] w);
    m_cmd = w & 32'hFFFF_FFFE;
    if (w[15:12] == 4'(PHY)) begin
      if (w[1]) begin
        if (w[7:4] == 4'd0) begin
          if (m_data[15]) begin m_ctrl = 16'h3100; m_adv = 16'h0; end
          else m_ctrl = m_data[15:0] & 16'h7DFF;
        end else if (w[7:4] == 4'd4) begin
          m_adv = m_data[15:0];
        end
      end else begin
        m_data = {16'd0, model_read(w[7:4])};
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 2'd0) model_cmd(v);
    else if (a == 2'd1) m_data = v;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic phy_read_chk(input string tag, input logic [3:0] idx);
    logic [31:0] v;
    bus_write(2'd0, mk_cmd(4'(PHY), idx, 1'b0));
    bus_read(2'd1, v);
    chk(tag, v, m_data);
  endtask

  task automatic phy_write(input logic [3:0] idx, input logic [15:0] val);
    bus_write(2'd1, {16'hA5A5, val});
    bus_write(2'd0, mk_cmd(4'(PHY), idx, 1'b1));
  endtask

  initial begin
    logic [31:0] v;
    m_cmd = 0; m_data = 0; m_ctrl = 16'h3100; m_adv = 0; m_link = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, v); chk("R1 cmd", v, 32'h0);
    bus_read(2'd1, v); chk("R1 data", v, 32'h0);
    phy_read_chk("R1 ctrl", 4'd0);
    chk("R1 ctrl value", m_data, 32'h3100);
    phy_read_chk("R1 adv", 4'd4);

    // R2 busy cleared, fields stored
    bus_write(2'd0, 32'h0000_F0F3);
    bus_read(2'd0, v); chk("R2 cmd busy clear", v, 32'h0000_F0F2);

    // R11 data word write/readback, other address reads 0
    bus_write(2'd1, 32'hDEAD_BEEF);
    bus_read(2'd1, v); chk("R11 data", v, 32'hDEAD_BEEF);
    bus_read(2'd2, v); chk("R11 unmapped", v, 32'h0);

    // R3 mismatched address: read leaves data, write leaves adv
    bus_write(2'd0, mk_cmd(4'(PHY + 1), 4'd2, 1'b0));
    bus_read(2'd1, v); chk("R3 data held", v, 32'hDEAD_BEEF);
    bus_write(2'd0, mk_cmd(4'd9, 4'd4, 1'b1));
    phy_read_chk("R3 adv held", 4'd4);
    chk("R3 adv value", m_data, 32'h0);

    // R4 control write masks 15/9 (bit15 clear here)
    phy_write(4'd0, 16'h7FFF);
    phy_read_chk("R4 ctrl masked", 4'd0);
    chk("R4 ctrl value", m_data, 32'h7DFF);

    // R9 advertisement
    phy_write(4'd4, 16'h05E1);
    phy_read_chk("R9 adv", 4'd4);
    chk("R9 adv value", m_data, 32'h05E1);

    // R5 PHY reset keeps link
    phy_write(4'd0, 16'h8000);
    phy_read_chk("R5 ctrl default", 4'd0);
    chk("R5 ctrl value", m_data, 32'h3100);
    phy_read_chk("R5 adv cleared", 4'd4);
    phy_read_chk("R5 link kept", 4'd1);
    chk("R5 status value", m_data, 32'hFE2C);

    // R7 identifiers and ignored writes
    phy_write(4'd2, 16'hFFFF);
    phy_write(4'd3, 16'h0000);
    phy_read_chk("R7 id high", 4'd2); chk("R7 id high value", m_data, 32'h0044);
    phy_read_chk("R7 id low", 4'd3);  chk("R7 id low value", m_data, 32'h1400);

    // R8 link partner
    phy_write(4'd5, 16'h0000);
    phy_read_chk("R8 lp", 4'd5); chk("R8 lp value", m_data, 32'h0DE0);

    // R10 unknown indices
    phy_write(4'd9, 16'hFFFF);
    phy_read_chk("R10 idx9", 4'd9); chk("R10 idx9 value", m_data, 32'h0);
    phy_read_chk("R10 idx15", 4'd15);
    phy_read_chk("R10 ctrl untouched", 4'd0);

    // R6 link drop in the same cycle as the read command: old value seen
    @(negedge clk);
    link_up = 1'b0; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = mk_cmd(4'(PHY), 4'd1, 1'b0);
    @(negedge clk);
    bus_wr = 1'b0;
    model_cmd(mk_cmd(4'(PHY), 4'd1, 1'b0));  // m_link still 1 here
    m_link = 1'b0;
    bus_read(2'd1, v); chk("R6 same-cycle old link", v, 32'hFE2C);
    phy_read_chk("R6 link down", 4'd1); chk("R6 status down", m_data, 32'hFE28);

    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) begin
        @(negedge clk);
        link_up = $urandom_range(0, 1); m_link = link_up;
      end else if (op <= 3) begin
        bus_write(2'd1, $urandom);
      end else if (op <= 7) begin
        logic [3:0] pa;
        pa = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'(PHY);
        bus_write(2'd0, {$urandom} & 32'hFFFF_F0F3 | {16'd0, pa, 12'd0} & 32'h0000_F000
                  | (mk_cmd(pa, 4'($urandom_range(0, 7)), 1'($urandom)) & 32'h0000_00F2));
      end else begin
        bus_read(2'd1, v); chk("R11 rand data", v, m_data);
        bus_read(2'd0, v); chk("R2 rand cmd", v, m_cmd);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule